// File: doc/BRIEF.md
# Calibrated DAC Code Datapath

This block sits between the register bank of a delta-sigma converter and its modulator. It holds the data word, the additive offset correction and the multiplicative gain correction. It turns the data word into the corrected unsigned output code that drives the modulator. The data word is left-justified in a 24-bit register. It is cut to 16 or 20 significant bits and read either as two's complement or as straight binary. The offset is added first, then the sum is scaled by the gain, and the result is clipped to the code range.

Register writes arrive as completed write commands with byte enables. While the converter sleeps, writes are kept but the corrections in use are frozen. They take effect on the first cycle of normal operation. A clear control and a calibration-restore control act only in normal operation.

A step detector compares each new output code with the previous one and raises a fast-settling request for the output filter. The request can be forced off or forced on.

Top module: `dac_code_path`

## Requirements
- R1: After a synchronous reset the output code is 0x80000 (mid-scale), the fast-settle flag is 0, the offset is 0 and the gain is unity, so a data value written after reset is converted without correction.
- R2: With `res_20b`=1 only data bits [23:4] are used. With `res_20b`=0 only bits [23:8] are used, and the low four bits of the output code are 0.
- R3: With `fmt_straight`=0 the data is two's complement and data 0 gives 0x80000. With `fmt_straight`=1 the data is straight binary and data 0 gives code 0.
- R4: The offset register is a 24-bit two's-complement value aligned with the data register's LSB. It is added to the data before the gain is applied.
- R5: The result is (data+offset)×gain/2^23, rounded toward minus infinity. A gain of 0x800000 is unity.
- R6: A result outside the 24-bit signed range saturates, giving output code 0xFFFFF or 0x00000 instead of wrapping. The output code is the top 20 bits of the result with the sign bit inverted.
- R7: With `mode_normal`=0, writes are stored but the output does not change. On the return to `mode_normal`=1 the stored values take effect.
- R8: A `cal_reset` pulse with `mode_normal`=1 sets the offset to 0 and the gain to 0x800000. With `mode_normal`=0 it has no effect.
- R9: A `clr_data` pulse with `mode_normal`=1 zeroes the data register and wins over a data write in the same cycle. With `mode_normal`=0 it has no effect.
- R10: `wr_sel` selects 0 = data, 1 = offset, 2 = gain, 3 = none. `wr_be[2]` covers bits [23:16] and `wr_be[0]` covers bits [7:0]. With `res_20b`=0, a data write whose only enable is `wr_be[0]` is dropped.
- R11: A write sampled at one rising edge changes the output code at the second rising edge after it.
- R12: With `fs_disable`=1 the fast-settle flag is 0.
- R13: With `fs_disable`=0 and `fs_always`=1 the fast-settle flag is 1.
- R14: With both controls 0, the flag goes to 1 when the output code moves by more than STEP_THRESH (default 0x2000, 1/128 of full scale) and stays there for HOLD_CYC cycles (default 16). A move of exactly the threshold, or less, leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_normal | input | 1 | 1 = normal operation, 0 = sleep |
| res_20b | input | 1 | 1 = 20-bit resolution, 0 = 16-bit |
| fmt_straight | input | 1 | 1 = straight binary data, 0 = two's complement |
| wr_en | input | 1 | Completed write command strobe |
| wr_sel | input | 2 | Target register of the write |
| wr_be | input | 3 | Byte enables of the write |
| wr_data | input | 24 | Write data |
| clr_data | input | 1 | Clear the data register |
| cal_reset | input | 1 | Restore offset and gain defaults |
| fs_disable | input | 1 | Force normal filter speed |
| fs_always | input | 1 | Force fast filter speed |
| code_o | output | 20 | Corrected unsigned modulator code |
| fast_o | output | 1 | Fast-settling request |

## Verification
A table of vectors drives the conversion with data at mid-scale, at both extremes and at odd values in each number format and resolution. This separates the truncation width and the sign handling. Positive and negative offsets are applied alone, and fractional gains are applied alone. One vector combines an offset with a gain, which separates add-then-scale from scale-then-add. Overflowing sums and products in both directions show saturation rather than wrap. Directed sequences then run writes and control pulses across sleep and normal operation, test partial-byte writes, and check the output one cycle before and at the cycle of change. They also give output steps just at, just above and well above the threshold.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_OFS  = 2'd1,
    SEL_GAIN = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/dcp_regfile.sv
module dcp_regfile
  import dcp_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    normal_i,
  input  logic                    res20_i,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [REG_W/BYTE_W-1:0] wr_be_i,
  input  logic [REG_W-1:0]        wr_data_i,
  input  logic                    clr_i,
  input  logic                    calrst_i,
  output logic [REG_W-1:0]        data_o,
  output logic [REG_W-1:0]        ofs_o,
  output logic [REG_W-1:0]        gain_o
);

  localparam int NB = REG_W / BYTE_W;
  localparam logic [REG_W-1:0] GAIN_UNITY = {1'b1, {(REG_W-1){1'b0}}};
  localparam logic [NB-1:0]    LOW_ONLY   = {{(NB-1){1'b0}}, 1'b1};

  // stored values (what software wrote) and values in use
  logic [REG_W-1:0] data_q, ofs_q, gain_q;
  logic [REG_W-1:0] data_n, ofs_n, gain_n;
  logic [REG_W-1:0] mrg_d, mrg_o, mrg_g;
  logic             drop_low;
  reg_sel_e         sel;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign mrg_d[b*BYTE_W +: BYTE_W] = wr_be_i[b] ? wr_data_i[b*BYTE_W +: BYTE_W] : data_q[b*BYTE_W +: BYTE_W];
    assign mrg_o[b*BYTE_W +: BYTE_W] = wr_be_i[b] ? wr_data_i[b*BYTE_W +: BYTE_W] : ofs_q[b*BYTE_W +: BYTE_W];
    assign mrg_g[b*BYTE_W +: BYTE_W] = wr_be_i[b] ? wr_data_i[b*BYTE_W +: BYTE_W] : gain_q[b*BYTE_W +: BYTE_W];
  end

  assign sel      = reg_sel_e'(wr_sel_i);
  assign drop_low = !res20_i && (wr_be_i == LOW_ONLY);

  always_comb begin
    data_n = data_q;
    ofs_n  = ofs_q;
    gain_n = gain_q;
    if (wr_en_i) begin
      case (sel)
        SEL_DATA: if (!drop_low) data_n = mrg_d;
        SEL_OFS:  ofs_n  = mrg_o;
        SEL_GAIN: gain_n = mrg_g;
        default:  ;
      endcase
    end
    if (normal_i && clr_i) data_n = '0;
    if (normal_i && calrst_i) begin
      ofs_n  = '0;
      gain_n = GAIN_UNITY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ofs_q  <= '0;
      gain_q <= GAIN_UNITY;
      data_o <= '0;
      ofs_o  <= '0;
      gain_o <= GAIN_UNITY;
    end else begin
      data_q <= data_n;
      ofs_q  <= ofs_n;
      gain_q <= gain_n;
      if (normal_i) begin
        data_o <= data_n;
        ofs_o  <= ofs_n;
        gain_o <= gain_n;
      end
    end
  end

  // R7: values in use are frozen while asleep
  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !normal_i |=> ($stable(data_o) && $stable(ofs_o) && $stable(gain_o)));

  // R8: calibration restore in normal operation
  p_calrst_r8: assert property (@(posedge clk) disable iff (rst)
    (normal_i && calrst_i) |=> (ofs_o == '0 && gain_o == GAIN_UNITY));

  // R9: clear in normal operation wins over a write
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (normal_i && clr_i) |=> (data_o == '0));

endmodule

// File: rtl/dcp_correct.sv
module dcp_correct #(
  parameter int REG_W  = 24,
  parameter int CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res20_i,
  input  logic              fmt_bin_i,
  input  logic [REG_W-1:0]  data_i,
  input  logic [REG_W-1:0]  ofs_i,
  input  logic [REG_W-1:0]  gain_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int GAIN_FRAC = REG_W - 1;
  localparam int SUM_W     = REG_W + 1;
  localparam int PROD_W    = SUM_W + REG_W + 1;
  localparam int DROP_HI   = REG_W - CODE_W;
  localparam int LOW16     = CODE_W - 16;
  localparam int RES_TOP   = GAIN_FRAC + REG_W - 1;
  localparam int RES_BOT   = GAIN_FRAC + DROP_HI;
  localparam int OVF_W     = PROD_W - RES_TOP;
  localparam logic [REG_W-1:0]  MASK_HI = {{CODE_W{1'b1}}, {DROP_HI{1'b0}}};
  localparam logic [REG_W-1:0]  MASK_LO = {{16{1'b1}}, {(REG_W-16){1'b0}}};
  localparam logic [CODE_W-1:0] MID     = {1'b1, {(CODE_W-1){1'b0}}};

  // stage 1: truncate, interpret, add offset
  logic [REG_W-1:0]        x;
  logic signed [SUM_W-1:0] sum_n, sum_q;
  logic [REG_W-1:0]        gain_q;
  logic                    res20_q;

  always_comb begin
    x = data_i & (res20_i ? MASK_HI : MASK_LO);
    if (fmt_bin_i) x[REG_W-1] = ~x[REG_W-1];
    sum_n = $signed({x[REG_W-1], x}) + $signed({ofs_i[REG_W-1], ofs_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      gain_q  <= {1'b1, {(REG_W-1){1'b0}}};
      res20_q <= 1'b1;
    end else begin
      sum_q   <= sum_n;
      gain_q  <= gain_i;
      res20_q <= res20_i;
    end
  end

  // stage 2: scale, saturate, map to unsigned code
  logic signed [PROD_W-1:0] op_a, op_b, prod;
  logic [OVF_W-1:0]         ovf_bits;
  logic [CODE_W-1:0]        res, ucode;
  logic                     unused_lsbs;

  always_comb begin
    op_a     = PROD_W'(sum_q);
    op_b     = PROD_W'({1'b0, gain_q});
    prod     = op_a * op_b;
    ovf_bits = prod[PROD_W-1:RES_TOP];
    if (ovf_bits == '0 || ovf_bits == '1)
      res = prod[RES_TOP:RES_BOT];
    else if (prod[PROD_W-1])
      res = {1'b1, {(CODE_W-1){1'b0}}};
    else
      res = {1'b0, {(CODE_W-1){1'b1}}};
    ucode = {~res[CODE_W-1], res[CODE_W-2:0]};
    if (!res20_q) ucode[LOW16-1:0] = '0;
  end

  assign unused_lsbs = ^prod[RES_BOT-1:0];

  always_ff @(posedge clk) begin
    if (rst) code_o <= MID;
    else     code_o <= ucode;
  end

  // R6: a non-negative sum never wraps into the lower half
  p_sign_kept_r6: assert property (@(posedge clk) disable iff (rst)
    !sum_q[SUM_W-1] |=> code_o[CODE_W-1]);

endmodule

// File: rtl/dcp_settle.sv
module dcp_settle #(
  parameter int CODE_W      = 20,
  parameter int STEP_THRESH = 8192,
  parameter int HOLD_CYC    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fs_dis_i,
  input  logic              fs_all_i,
  output logic              fast_o
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CODE_W:0]     THR  = (CODE_W+1)'(STEP_THRESH);
  localparam logic [CNT_W-1:0]    HOLD = CNT_W'(HOLD_CYC);
  localparam logic [CODE_W-1:0]   MID  = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] prev_q;
  logic [CODE_W:0]   diff, mag;
  logic              step;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    diff  = {1'b0, code_i} - {1'b0, prev_q};
    mag   = diff[CODE_W] ? -diff : diff;
    step  = mag > THR;
    if (step)            cnt_n = HOLD;
    else if (cnt_q != 0) cnt_n = cnt_q - CNT_W'(1);
    else                 cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= MID;
      cnt_q  <= '0;
      fast_o <= 1'b0;
    end else begin
      prev_q <= code_i;
      cnt_q  <= cnt_n;
      if (fs_dis_i)      fast_o <= 1'b0;
      else if (fs_all_i) fast_o <= 1'b1;
      else               fast_o <= (cnt_n != 0);
    end
  end

  p_fs_off_r12: assert property (@(posedge clk) disable iff (rst)
    fs_dis_i |=> !fast_o);

  p_fs_on_r13: assert property (@(posedge clk) disable iff (rst)
    (!fs_dis_i && fs_all_i) |=> fast_o);

endmodule

// File: rtl/dac_code_path.sv
module dac_code_path #(
  parameter int REG_W       = 24,
  parameter int CODE_W      = 20,
  parameter int HOLD_CYC    = 16,
  parameter int STEP_THRESH = (2 ** CODE_W) / 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_normal,
  input  logic              res_20b,
  input  logic              fmt_straight,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              clr_data,
  input  logic              cal_reset,
  input  logic              fs_disable,
  input  logic              fs_always,
  output logic [CODE_W-1:0] code_o,
  output logic              fast_o
);

  logic [REG_W-1:0] data_a, ofs_a, gain_a;

  dcp_regfile #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .normal_i  (mode_normal),
    .res20_i   (res_20b),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_be_i   (wr_be),
    .wr_data_i (wr_data),
    .clr_i     (clr_data),
    .calrst_i  (cal_reset),
    .data_o    (data_a),
    .ofs_o     (ofs_a),
    .gain_o    (gain_a)
  );

  dcp_correct #(.REG_W(REG_W), .CODE_W(CODE_W)) u_corr (
    .clk       (clk),
    .rst       (rst),
    .res20_i   (res_20b),
    .fmt_bin_i (fmt_straight),
    .data_i    (data_a),
    .ofs_i     (ofs_a),
    .gain_i    (gain_a),
    .code_o    (code_o)
  );

  dcp_settle #(.CODE_W(CODE_W), .STEP_THRESH(STEP_THRESH), .HOLD_CYC(HOLD_CYC)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .code_i   (code_o),
    .fs_dis_i (fs_disable),
    .fs_all_i (fs_always),
    .fast_o   (fast_o)
  );

endmodule

// File: tb/dac_code_path_tb_top.sv
module dac_code_path_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_normal = 1'b0, res_20b = 1'b1, fmt_straight = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [2:0]  wr_be = 3'd0;
  logic [23:0] wr_data = '0;
  logic        clr_data = 1'b0, cal_reset = 1'b0;
  logic        fs_disable = 1'b1, fs_always = 1'b0;
  logic [19:0] code_o;
  logic        fast_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_code_path dut_i (
    .clk(clk), .rst(rst), .mode_normal(mode_normal), .res_20b(res_20b),
    .fmt_straight(fmt_straight), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .clr_data(clr_data), .cal_reset(cal_reset),
    .fs_disable(fs_disable), .fs_always(fs_always), .code_o(code_o), .fast_o(fast_o)
  );

  typedef struct packed {
    logic [23:0] data;
    logic [23:0] ofs;
    logic [23:0] gain;
    logic        res20;
    logic        fmt;
    logic [19:0] exp;
  } vec_t;

  localparam vec_t VECS [0:13] = '{
    '{24'h000000, 24'h000000, 24'h800000, 1'b1, 1'b0, 20'h80000}, // R3 two's comp zero
    '{24'h000000, 24'h000000, 24'h800000, 1'b1, 1'b1, 20'h00000}, // R3 straight zero
    '{24'h800000, 24'h000000, 24'h800000, 1'b1, 1'b1, 20'h80000}, // R3 straight mid
    '{24'h123456, 24'h000000, 24'h800000, 1'b1, 1'b0, 20'h92345}, // R2 20-bit
    '{24'h123456, 24'h000000, 24'h800000, 1'b0, 1'b0, 20'h92340}, // R2 16-bit
    '{24'hFFFFFF, 24'h000000, 24'h800000, 1'b1, 1'b1, 20'hFFFFF}, // R2 top code
    '{24'h000000, 24'h000100, 24'h800000, 1'b1, 1'b0, 20'h80010}, // R4 positive offset
    '{24'h000000, 24'hFFFF00, 24'h800000, 1'b1, 1'b0, 20'h7FFF0}, // R4 negative offset
    '{24'h200000, 24'h000000, 24'h400000, 1'b1, 1'b0, 20'h90000}, // R5 half gain
    '{24'hF00000, 24'h000000, 24'h600000, 1'b1, 1'b0, 20'h74000}, // R5 3/4 gain negative
    '{24'h7FFFF0, 24'h000000, 24'hFFFFFF, 1'b1, 1'b0, 20'hFFFFF}, // R6 gain overflow
    '{24'h7FFFF0, 24'h000100, 24'h800000, 1'b1, 1'b0, 20'hFFFFF}, // R6 offset overflow
    '{24'h800000, 24'hFFFF00, 24'h800000, 1'b1, 1'b0, 20'h00000}, // R6 underflow
    '{24'h200000, 24'h200000, 24'h400000, 1'b1, 1'b0, 20'hA0000}  // R4 add before scale
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [2:0] be, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_be = 3'd0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_data = 1'b1;
    @(negedge clk); clr_data = 1'b0;
  endtask

  task automatic pulse_cal();
    @(negedge clk); cal_reset = 1'b1;
    @(negedge clk); cal_reset = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 reset code", code_o, 20'h80000);
    check("R1 reset fast", fast_o, 1'b0);
    mode_normal = 1'b1;
    wr(2'd0, 3'b111, 24'h200000);
    idle(4);
    check("R1 default offset/gain", code_o, 20'hA0000);

    // table walk
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      res_20b = VECS[i].res20; fmt_straight = VECS[i].fmt;
      wr(2'd1, 3'b111, VECS[i].ofs);
      wr(2'd2, 3'b111, VECS[i].gain);
      wr(2'd0, 3'b111, VECS[i].data);
      idle(4);
      check($sformatf("table vector %0d (R2 R3 R4 R5 R6)", i), code_o, VECS[i].exp);
    end

    // R8 calibration restore, normal then sleep
    wr(2'd0, 3'b111, 24'h100000);
    idle(4);
    check("R8 before restore", code_o, 20'h98000);
    pulse_cal();
    idle(4);
    check("R8 restore in normal", code_o, 20'h90000);
    wr(2'd1, 3'b111, 24'h001000);
    idle(4);
    check("R4 offset after restore", code_o, 20'h90100);
    @(negedge clk); mode_normal = 1'b0;
    pulse_cal();
    @(negedge clk); mode_normal = 1'b1;
    idle(4);
    check("R8 restore ignored in sleep", code_o, 20'h90100);

    // R7 sleep freezing
    @(negedge clk); mode_normal = 1'b0;
    wr(2'd0, 3'b111, 24'h400000);
    idle(4);
    check("R7 sleep holds output", code_o, 20'h90100);
    @(negedge clk); mode_normal = 1'b1;
    idle(4);
    check("R7 applied on wake", code_o, 20'hC0100);
    pulse_cal();
    idle(4);
    check("R8 second restore", code_o, 20'hC0000);

    // R9 clear
    pulse_clr();
    idle(4);
    check("R9 clear in normal", code_o, 20'h80000);
    wr(2'd0, 3'b111, 24'h400000);
    idle(4);
    @(negedge clk); mode_normal = 1'b0;
    pulse_clr();
    @(negedge clk); mode_normal = 1'b1;
    idle(4);
    check("R9 clear ignored in sleep", code_o, 20'hC0000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_be = 3'b111; wr_data = 24'h300000; clr_data = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_be = 3'd0; clr_data = 1'b0;
    idle(4);
    check("R9 clear beats write", code_o, 20'h80000);

    // R10 byte writes
    @(negedge clk); res_20b = 1'b0;
    wr(2'd0, 3'b111, 24'h123456);
    idle(4);
    check("R2 16-bit", code_o, 20'h92340);
    wr(2'd0, 3'b001, 24'h0000AB);
    idle(4);
    check("R10 low byte alone dropped (16-bit)", code_o, 20'h92340);
    @(negedge clk); res_20b = 1'b1;
    idle(4);
    check("R10 low byte not stored", code_o, 20'h92345);
    wr(2'd0, 3'b001, 24'h000070);
    idle(4);
    check("R10 low byte in 20-bit", code_o, 20'h92347);
    wr(2'd0, 3'b100, 24'hA50000);
    idle(4);
    check("R10 top byte merge", code_o, 20'h25347);
    wr(2'd3, 3'b111, 24'h000000);
    idle(4);
    check("R10 select none ignored", code_o, 20'h25347);

    // R11 latency
    wr(2'd0, 3'b111, 24'h000000);
    @(negedge clk);
    check("R11 one edge after write", code_o, 20'h25347);
    @(negedge clk);
    check("R11 second edge after write", code_o, 20'h80000);

    // R12 / R13 fast-settle overrides
    wr(2'd0, 3'b111, 24'h300000);
    idle(4);
    check("R12 code", code_o, 20'hB0000);
    check("R12 disabled despite step", fast_o, 1'b0);
    @(negedge clk); fs_disable = 1'b0; fs_always = 1'b1;
    idle(2);
    check("R13 forced on", fast_o, 1'b1);
    @(negedge clk); fs_disable = 1'b1;
    idle(2);
    check("R12 disable beats always", fast_o, 1'b0);

    // R14 adaptive
    @(negedge clk); fs_disable = 1'b0; fs_always = 1'b0;
    idle(40);
    check("R14 idle off", fast_o, 1'b0);
    wr(2'd0, 3'b111, 24'h000000);
    idle(4);
    check("R14 large step on", fast_o, 1'b1);
    idle(40);
    check("R14 hold expired", fast_o, 1'b0);
    wr(2'd0, 3'b111, 24'h001000);
    idle(4);
    check("R14 small step code", code_o, 20'h80100);
    check("R14 small step off", fast_o, 1'b0);
    wr(2'd0, 3'b111, 24'h021000);
    idle(4);
    check("R14 step equal to threshold", fast_o, 1'b0);
    wr(2'd0, 3'b111, 24'h000F00);
    idle(4);
    check("R14 step just above threshold code", code_o, 20'h800F0);
    check("R14 step just above threshold", fast_o, 1'b1);

    finish_run();
  end

endmodule